// File: doc/BRIEF.md
# Host Slave Access Router for Local Memories and Peripherals

This block sits on the target side of a host bus. It accepts one single-beat 32-bit access at a time: address, byte enables, read/write flag and write data. Each access goes to one of three local destinations. Host address bit 16 picks between two spaces. The low space is a 64 KB control-memory window. Seven of its eight KB-ranges map onto a word-wide control memory, which is split into named regions. The 0xC000–0xDFFF range instead reaches an 8-bit peripheral register port. The high space reaches a byte-wide boot EPROM of up to 8 KB.

The block turns byte enables into byte-lane choices. For the peripheral port it picks the single valid write byte and copies a read byte into all four lanes. For the EPROM it gathers one byte per enabled lane. Malformed accesses are answered with an error and are never forwarded. Each local port uses a request/acknowledge handshake, and the target may stretch it by any number of wait cycles. The host sees a one-cycle ready pulse once the access is complete.

Top module: `slv_route_bridge`

## Requirements
- R1: With `h_addr[16]`=0, the 16-bit offset `h_addr[15:0]` is decoded on `cm_region` as follows: 0 = below 0x0400, 1 = 0x0400–0x23FF, 2 = 0x2400–0x3FFF, 3 = 0x4000–0xBFFF, 5 = 0xE000–0xFFFF. The range 0xC000–0xDFFF (code 4) goes to the peripheral port and never raises `cm_req`.
- R2: A control-memory access sends word address `h_addr[15:2]` on `cm_addr`, passes `h_wdata` unchanged on a write, and returns the 32-bit `cm_rdata` unchanged to `h_rdata` on a read.
- R3: A control-memory access with `h_addr[1:0]` not 0, or with `h_be` not 4'b1111, ends with `h_err`=1 and raises no `cm_req`.
- R4: A peripheral write with exactly one byte enable set drives byte lane k of `h_wdata` (bits 8k+7:8k, where k is the set bit of `h_be`) on `phy_wdata`, with `phy_addr` = {`h_addr[12:2]`, k}.
- R5: A peripheral write with zero or several byte enables set ends with `h_err`=1 and raises no `phy_req`.
- R6: A peripheral read uses the lowest enabled lane k (0 when `h_be` is 0) for `phy_addr` = {`h_addr[12:2]`, k}, and returns the received byte copied into all four lanes of `h_rdata`.
- R7: An EPROM read performs one byte fetch per set bit of `h_be`, in ascending lane order, at `rom_addr` = {`h_addr[12:2]`, lane}. Each byte is placed in its own lane of `h_rdata`, and lanes that are not enabled read 0.
- R8: An EPROM access that is a write, has `h_be`=0, or has `h_addr[15:13]` not 0 ends with `h_err`=1 and performs no fetch.
- R9: Each local request stays high until acknowledged, at most one local request is high at a time, and `h_rdy` is a one-cycle pulse issued one cycle after the final acknowledge. `h_err` is high only together with `h_rdy`.
- R10: `h_req` is ignored while an access is in progress: it produces no extra ready pulse and no extra local transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request (sampled when idle) |
| h_addr | input | 17 | Host byte address; bit 16 selects the EPROM space |
| h_be | input | 4 | Host byte enables, bit k for lane k |
| h_we | input | 1 | 1 = write, 0 = read |
| h_wdata | input | 32 | Host write data |
| h_rdy | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Access rejected, valid with h_rdy |
| h_rdata | output | 32 | Read data, valid with h_rdy |
| cm_req | output | 1 | Control-memory request |
| cm_we | output | 1 | Control-memory write flag |
| cm_addr | output | 14 | Control-memory word address |
| cm_region | output | 3 | Decoded region code |
| cm_wdata | output | 32 | Control-memory write data |
| cm_ack | input | 1 | Control-memory acknowledge |
| cm_rdata | input | 32 | Control-memory read data |
| phy_req | output | 1 | Peripheral register request |
| phy_we | output | 1 | Peripheral write flag |
| phy_addr | output | 13 | Peripheral byte address |
| phy_wdata | output | 8 | Peripheral write byte |
| phy_ack | input | 1 | Peripheral acknowledge |
| phy_rdata | input | 8 | Peripheral read byte |
| rom_req | output | 1 | EPROM byte fetch request |
| rom_addr | output | 13 | EPROM byte address |
| rom_ack | input | 1 | EPROM acknowledge |
| rom_rdata | input | 8 | EPROM read byte |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, a 14-bit word address and an 8 KB EPROM. At this size all sixteen byte-enable patterns can be swept for every destination and every control-memory region. Each local responder returns data computed from the address it receives and inserts between zero and five wait cycles. This exposes lane ordering, fetch counts, hold behaviour and the busy-time request rejection to direct arithmetic comparison.

// File: rtl/slvbr_pkg.sv
package slvbr_pkg;

   localparam int P_LANES  = 4;
   localparam int P_LANE_W = 8;

   typedef enum logic [1:0] {TGT_CM, TGT_PHY, TGT_ROM} tgt_e;

   typedef enum logic [2:0] {
      RG_INIT  = 3'd0,
      RG_TXDMA = 3'd1,
      RG_BWG   = 3'd2,
      RG_RXDMA = 3'd3,
      RG_PHY   = 3'd4,
      RG_USER  = 3'd5
   } region_e;

   // region limits (exclusive upper bounds) inside the 16-bit window
   localparam logic [15:0] LIM_INIT  = 16'h0400;
   localparam logic [15:0] LIM_TXDMA = 16'h2400;
   localparam logic [15:0] LIM_BWG   = 16'h4000;
   localparam logic [15:0] LIM_RXDMA = 16'hC000;
   localparam logic [15:0] LIM_PHY   = 16'hE000;

   function automatic logic [1:0] low_lane(input logic [P_LANES-1:0] be);
      logic [1:0] r;
      r = 2'd0;
      for (int i = P_LANES - 1; i >= 0; i--)
         if (be[i]) r = 2'(i);
      return r;
   endfunction

   function automatic logic single_bit(input logic [P_LANES-1:0] be);
      return (be != '0) && ((be & (be - 1'b1)) == '0);
   endfunction

endpackage

// File: rtl/slvbr_decode.sv
module slvbr_decode
   import slvbr_pkg::*;
#(
   parameter int CM_AW  = 14,
   parameter int ROM_AW = 13,
   parameter int LANES  = 4,
   localparam int WIN_W = CM_AW + 2,
   localparam int HA_W  = WIN_W + 1
) (
   input  logic [HA_W-1:0]  addr,
   input  logic [LANES-1:0] be,
   input  logic             we,
   output tgt_e             tgt,
   output region_e          region,
   output logic             err
);

   logic [WIN_W-1:0] off;
   assign off = addr[WIN_W-1:0];

   always_comb begin
      if      (off < LIM_INIT)  region = RG_INIT;
      else if (off < LIM_TXDMA) region = RG_TXDMA;
      else if (off < LIM_BWG)   region = RG_BWG;
      else if (off < LIM_RXDMA) region = RG_RXDMA;
      else if (off < LIM_PHY)   region = RG_PHY;
      else                      region = RG_USER;
   end

   always_comb begin
      if (addr[HA_W-1]) begin
         tgt = TGT_ROM;
         err = we || (be == '0) || (off[WIN_W-1:ROM_AW] != '0);
      end else if (region == RG_PHY) begin
         tgt = TGT_PHY;
         err = we && !single_bit(be);
      end else begin
         tgt = TGT_CM;
         err = (off[1:0] != 2'b00) || (be != {LANES{1'b1}});
      end
   end

endmodule

// File: rtl/slvbr_lanes.sv
module slvbr_lanes #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [SEL_W-1:0]  lane,
   input  logic [DW-1:0]     wdata,
   input  logic [LANE_W-1:0] byte_in,
   output logic [LANE_W-1:0] sel_byte,
   output logic [DW-1:0]     rep
);

   assign sel_byte = wdata[lane*LANE_W +: LANE_W];

   for (genvar g = 0; g < LANES; g++) begin : g_rep
      assign rep[g*LANE_W +: LANE_W] = byte_in;
   end

endmodule

// File: rtl/slv_route_bridge.sv
module slv_route_bridge
   import slvbr_pkg::*;
#(
   parameter int CM_AW  = 14,
   parameter int ROM_AW = 13,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W,
   localparam int WIN_W = CM_AW + 2,
   localparam int HA_W  = WIN_W + 1,
   localparam int PHY_AW = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic [HA_W-1:0]   h_addr,
   input  logic [LANES-1:0]  h_be,
   input  logic              h_we,
   input  logic [DW-1:0]     h_wdata,
   output logic              h_rdy,
   output logic              h_err,
   output logic [DW-1:0]     h_rdata,
   output logic              cm_req,
   output logic              cm_we,
   output logic [CM_AW-1:0]  cm_addr,
   output logic [2:0]        cm_region,
   output logic [DW-1:0]     cm_wdata,
   input  logic              cm_ack,
   input  logic [DW-1:0]     cm_rdata,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [LANE_W-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [LANE_W-1:0] phy_rdata,
   output logic              rom_req,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic              rom_ack,
   input  logic [LANE_W-1:0] rom_rdata
);

   if (CM_AW != 14) begin : g_bad_cm
      $error("slv_route_bridge: region map needs CM_AW == 14");
   end
   if (LANES != P_LANES || LANE_W != P_LANE_W) begin : g_bad_lane
      $error("slv_route_bridge: lane geometry must match package");
   end
   if (ROM_AW < 3 || ROM_AW >= WIN_W) begin : g_bad_rom
      $error("slv_route_bridge: ROM_AW out of range");
   end

   typedef enum logic [2:0] {ST_IDLE, ST_CM, ST_PHY, ST_ROM, ST_RESP} st_e;

   st_e              st;
   logic [WIN_W-1:0] a_q;
   logic             we_q;
   logic [DW-1:0]    wd_q;
   logic [DW-1:0]    rd_q;
   logic             err_q;
   logic [1:0]       lane_q;
   logic [LANES-1:0] mask_q;
   logic [LANE_W-1:0] byte_q;
   region_e          region_q;

   tgt_e              d_tgt;
   region_e           d_region;
   logic              d_err;
   logic [1:0]        h_lane;
   logic [1:0]        rlane;
   logic [LANE_W-1:0] h_byte;
   logic [DW-1:0]     phy_rep;

   slvbr_decode #(.CM_AW(CM_AW), .ROM_AW(ROM_AW), .LANES(LANES)) u_dec (
      .addr   (h_addr),
      .be     (h_be),
      .we     (h_we),
      .tgt    (d_tgt),
      .region (d_region),
      .err    (d_err)
   );

   assign h_lane = low_lane(h_be);
   assign rlane  = low_lane(mask_q);

   slvbr_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .lane     (h_lane),
      .wdata    (h_wdata),
      .byte_in  (phy_rdata),
      .sel_byte (h_byte),
      .rep      (phy_rep)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         a_q      <= '0;
         we_q     <= 1'b0;
         wd_q     <= '0;
         rd_q     <= '0;
         err_q    <= 1'b0;
         lane_q   <= '0;
         mask_q   <= '0;
         byte_q   <= '0;
         region_q <= RG_INIT;
      end else begin
         unique case (st)
            ST_IDLE: if (h_req) begin
               a_q      <= h_addr[WIN_W-1:0];
               we_q     <= h_we;
               wd_q     <= h_wdata;
               rd_q     <= '0;
               lane_q   <= h_lane;
               mask_q   <= h_be;
               byte_q   <= h_byte;
               region_q <= d_region;
               err_q    <= d_err;
               if (d_err) st <= ST_RESP;
               else begin
                  unique case (d_tgt)
                     TGT_CM:  st <= ST_CM;
                     TGT_PHY: st <= ST_PHY;
                     default: st <= ST_ROM;
                  endcase
               end
            end
            ST_CM: if (cm_ack) begin
               if (!we_q) rd_q <= cm_rdata;
               st <= ST_RESP;
            end
            ST_PHY: if (phy_ack) begin
               if (!we_q) rd_q <= phy_rep;
               st <= ST_RESP;
            end
            ST_ROM: if (rom_ack) begin
               rd_q[rlane*LANE_W +: LANE_W] <= rom_rdata;
               mask_q[rlane] <= 1'b0;
               if ((mask_q & ~(LANES'(1) << rlane)) == '0) st <= ST_RESP;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign h_rdy     = (st == ST_RESP);
   assign h_err     = (st == ST_RESP) && err_q;
   assign h_rdata   = rd_q;

   assign cm_req    = (st == ST_CM);
   assign cm_we     = we_q;
   assign cm_addr   = a_q[WIN_W-1:2];
   assign cm_region = region_q;
   assign cm_wdata  = wd_q;

   assign phy_req   = (st == ST_PHY);
   assign phy_we    = we_q;
   assign phy_addr  = {a_q[PHY_AW-1:2], lane_q};
   assign phy_wdata = byte_q;

   assign rom_req   = (st == ST_ROM);
   assign rom_addr  = {a_q[ROM_AW-1:2], rlane};

endmodule

// File: rtl/slvbr_chk.sv
module slvbr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       h_rdy,
   input logic       h_err,
   input logic       cm_req,
   input logic       cm_ack,
   input logic [2:0] cm_region,
   input logic       phy_req,
   input logic       phy_ack,
   input logic       rom_req,
   input logic       rom_ack
);

   assert_rdy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      h_rdy |=> !h_rdy);

   assert_err_with_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      h_err |-> h_rdy);

   assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cm_req, phy_req, rom_req}));

   assert_cm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cm_req && !cm_ack |=> cm_req);

   assert_phy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req && !phy_ack |=> phy_req);

   assert_rom_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req && !rom_ack |=> rom_req);

   assert_no_phy_to_cm_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cm_req |-> cm_region != 3'd4);

   assert_no_req_during_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      h_rdy |-> !(cm_req || phy_req || rom_req));

endmodule

bind slv_route_bridge slvbr_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .h_rdy     (h_rdy),
   .h_err     (h_err),
   .cm_req    (cm_req),
   .cm_ack    (cm_ack),
   .cm_region (cm_region),
   .phy_req   (phy_req),
   .phy_ack   (phy_ack),
   .rom_req   (rom_req),
   .rom_ack   (rom_ack)
);

// File: tb/tb_slv_route_bridge.sv
`timescale 1ns/1ps
module tb_slv_route_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0;
   logic [16:0] h_addr = '0;
   logic [3:0]  h_be = '0;
   logic        h_we = 1'b0;
   logic [31:0] h_wdata = '0;
   logic        h_rdy, h_err;
   logic [31:0] h_rdata;
   logic        cm_req, cm_we;
   logic [13:0] cm_addr;
   logic [2:0]  cm_region;
   logic [31:0] cm_wdata;
   logic        cm_ack = 1'b0;
   logic [31:0] cm_rdata = '0;
   logic        phy_req, phy_we;
   logic [12:0] phy_addr;
   logic [7:0]  phy_wdata;
   logic        phy_ack = 1'b0;
   logic [7:0]  phy_rdata = '0;
   logic        rom_req;
   logic [12:0] rom_addr;
   logic        rom_ack = 1'b0;
   logic [7:0]  rom_rdata = '0;

   always #4 clk = ~clk;

   slv_route_bridge dut (.*);

   int n_chk = 0, n_fail = 0;
   int wt = 0;
   int cm_cnt = 0, phy_cnt = 0, rom_cnt = 0;
   int n_cm = 0, n_phy = 0, n_rom = 0, n_rdy = 0;
   logic [13:0] l_cm_addr;  logic l_cm_we;  logic [31:0] l_cm_wd;  logic [2:0] l_cm_rg;
   logic [12:0] l_phy_addr; logic l_phy_we; logic [7:0] l_phy_wd;
   logic [12:0] rom_log [4];

   // local responders with a programmable wait
   always @(posedge clk) begin
      if (cm_ack) cm_ack <= 1'b0;
      else if (cm_req) begin
         if (cm_cnt >= wt) begin
            cm_ack <= 1'b1; cm_cnt <= 0; n_cm <= n_cm + 1;
            cm_rdata <= {cm_addr, 4'hA, cm_addr};
            l_cm_addr <= cm_addr; l_cm_we <= cm_we; l_cm_wd <= cm_wdata; l_cm_rg <= cm_region;
         end else cm_cnt <= cm_cnt + 1;
      end
      if (phy_ack) phy_ack <= 1'b0;
      else if (phy_req) begin
         if (phy_cnt >= wt) begin
            phy_ack <= 1'b1; phy_cnt <= 0; n_phy <= n_phy + 1;
            phy_rdata <= phy_addr[7:0] ^ 8'h5C;
            l_phy_addr <= phy_addr; l_phy_we <= phy_we; l_phy_wd <= phy_wdata;
         end else phy_cnt <= phy_cnt + 1;
      end
      if (rom_ack) rom_ack <= 1'b0;
      else if (rom_req) begin
         if (rom_cnt >= wt) begin
            rom_ack <= 1'b1; rom_cnt <= 0; n_rom <= n_rom + 1;
            rom_rdata <= rom_addr[7:0] + 8'h31;
            rom_log[n_rom % 4] <= rom_addr;
         end else rom_cnt <= rom_cnt + 1;
      end
      if (h_rdy) n_rdy <= n_rdy + 1;
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [16:0] a, input logic [3:0] be, input logic we,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er);
      @(negedge clk);
      h_addr = a; h_be = be; h_we = we; h_wdata = wd; h_req = 1'b1;
      @(negedge clk);
      h_req = 1'b0;
      while (!h_rdy) @(negedge clk);
      rd = h_rdata; er = h_err;
      @(negedge clk);
   endtask

   function automatic logic [2:0] exp_rg(input logic [15:0] o);
      if (o < 16'h0400) return 3'd0;
      if (o < 16'h2400) return 3'd1;
      if (o < 16'h4000) return 3'd2;
      if (o < 16'hC000) return 3'd3;
      if (o < 16'hE000) return 3'd4;
      return 3'd5;
   endfunction

   function automatic int lowbit(input logic [3:0] be);
      for (int i = 0; i < 4; i++) if (be[i]) return i;
      return 0;
   endfunction

   function automatic int ones(input logic [3:0] be);
      return int'(be[0]) + int'(be[1]) + int'(be[2]) + int'(be[3]);
   endfunction

   logic [15:0] cm_pts [10] = '{16'h0000, 16'h03FC, 16'h0400, 16'h23FC, 16'h2400,
                                16'h3FFC, 16'h4000, 16'hBFFC, 16'hE000, 16'hFFFC};

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R9 actual=hang expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd; logic er; int c0; int r0; logic [31:0] exp;
      repeat (3) @(negedge clk);
      chk(!h_rdy && !cm_req && !phy_req && !rom_req, "R9 reset idle", {28'd0, h_rdy, cm_req, phy_req, rom_req}, 0);
      rst_n = 1'b1;

      // R1 R2: control memory write and read across all region edges
      foreach (cm_pts[i]) begin
         wt = i % 4;
         acc({1'b0, cm_pts[i]}, 4'hF, 1'b1, 32'hC0DE0000 + i, rd, er);
         chk(!er && l_cm_we && l_cm_addr == cm_pts[i][15:2] && l_cm_wd == 32'hC0DE0000 + i,
             "R2 cm write", {17'd0, er, l_cm_addr}, {18'd0, cm_pts[i][15:2]});
         chk(l_cm_rg == exp_rg(cm_pts[i]), "R1 region code", l_cm_rg, exp_rg(cm_pts[i]));
         acc({1'b0, cm_pts[i]}, 4'hF, 1'b0, 32'h0, rd, er);
         exp = {cm_pts[i][15:2], 4'hA, cm_pts[i][15:2]};
         chk(!er && !l_cm_we && rd == exp, "R2 cm read", rd, exp);
      end

      // R3: partial enables and misalignment rejected
      foreach (cm_pts[i]) begin
         for (int be = 0; be < 15; be++) begin
            c0 = n_cm;
            acc({1'b0, cm_pts[i]}, 4'(be), be[0], 32'h1, rd, er);
            chk(er && n_cm == c0, "R3 partial enable", {31'd0, er}, 1);
         end
         for (int m = 1; m < 4; m++) begin
            c0 = n_cm;
            acc({1'b0, cm_pts[i] | 16'(m)}, 4'hF, 1'b0, 32'h0, rd, er);
            chk(er && n_cm == c0, "R3 misaligned", {31'd0, er}, 1);
         end
      end

      // R4 R5 R6: peripheral window, all enable patterns
      for (int be = 0; be < 16; be++) begin
         wt = be % 3;
         c0 = n_phy;
         acc(17'h0C5A8, 4'(be), 1'b1, 32'hA1B2C3D4, rd, er);
         if (ones(4'(be)) == 1) begin
            exp = {24'd0, 8'(32'hA1B2C3D4 >> (8 * lowbit(4'(be))))};
            chk(!er && n_phy == c0 + 1 && l_phy_we && l_phy_wd == exp[7:0],
                "R4 phy write byte", {24'd0, l_phy_wd}, exp);
            chk(l_phy_addr == {11'h16A, 2'(lowbit(4'(be)))}, "R4 phy write addr",
                {19'd0, l_phy_addr}, {19'd0, 11'h16A, 2'(lowbit(4'(be)))});
         end else begin
            chk(er && n_phy == c0, "R5 phy write bad enables", {31'd0, er}, 1);
         end
         acc(17'h0DFF0, 4'(be), 1'b0, 32'h0, rd, er);
         exp = {4{8'({11'h3FC, 2'(lowbit(4'(be)))}) ^ 8'h5C}};
         chk(!er && !l_phy_we && rd == exp, "R6 phy read replicate", rd, exp);
      end

      // R7: EPROM gathering for every non-empty enable pattern
      for (int be = 1; be < 16; be++) begin
         wt = (be * 7) % 6;
         r0 = n_rom;
         acc(17'h11234, 4'(be), 1'b0, 32'h0, rd, er);
         exp = 0;
         for (int l = 0; l < 4; l++)
            if (be[l]) exp[8*l +: 8] = 8'({11'h48D, 2'(l)}) + 8'h31;
         chk(!er && rd == exp, "R7 rom assembled data", rd, exp);
         chk(n_rom == r0 + ones(4'(be)), "R7 rom fetch count", n_rom - r0, ones(4'(be)));
         chk(rom_log[r0 % 4] == {11'h48D, 2'(lowbit(4'(be)))}, "R7 rom first lane",
             {19'd0, rom_log[r0 % 4]}, {19'd0, 11'h48D, 2'(lowbit(4'(be)))});
      end

      // R8: EPROM rejections
      r0 = n_rom;
      acc(17'h10010, 4'hF, 1'b1, 32'h5, rd, er);
      chk(er && n_rom == r0, "R8 rom write", {31'd0, er}, 1);
      acc(17'h10010, 4'h0, 1'b0, 32'h0, rd, er);
      chk(er && n_rom == r0, "R8 rom empty enables", {31'd0, er}, 1);
      acc(17'h12000, 4'hF, 1'b0, 32'h0, rd, er);
      chk(er && n_rom == r0, "R8 rom beyond 8K", {31'd0, er}, 1);
      acc(17'h1FFFC, 4'h1, 1'b0, 32'h0, rd, er);
      chk(er && n_rom == r0, "R8 rom top of space", {31'd0, er}, 1);

      // R10: second request while busy is dropped
      wt = 5;
      c0 = n_cm; r0 = n_rdy;
      @(negedge clk);
      h_addr = 17'h00100; h_be = 4'hF; h_we = 1'b0; h_req = 1'b1;
      @(negedge clk); h_req = 1'b0;
      @(negedge clk); h_addr = 17'h04000; h_req = 1'b1;
      @(negedge clk); h_req = 1'b0;
      repeat (20) @(negedge clk);
      chk(n_cm == c0 + 1 && n_rdy == r0 + 1 && l_cm_addr == 14'h0040, "R10 busy request ignored",
          n_rdy - r0, 1);

      // R9: one ready per completed access overall
      chk(n_rdy > 0 && !h_rdy, "R9 ready returns low", {31'd0, h_rdy}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule